// File: doc/BRIEF.md
# Leveled Timer Interrupt Controller

This block gathers the underflow pulses of three timer channels and turns them into one prioritised interrupt request toward a processor core. Each pulse latches a per-channel pending flag. The flag latches even while the channel is masked. Each channel also has an enable bit and a 3-bit level. Among the channels that are both pending and enabled, the block picks a winner by level, and lower channel index breaks ties. The winner is offered to the core only if the core has interrupts enabled, no higher-priority cause (such as a non-maskable interrupt) is active, and the winner's level is strictly above the core's current level field.

Software reads and writes the flag, enable and level fields through a small register port selected by a 2-bit register index. A pending flag is cleared by writing 1 to its bit. The core clears the flag of the channel being serviced with a one-cycle acknowledge. The request line, vector number, vector address and level outputs all come from registers.

Top module: `tic_top`

## Requirements
- R1: An underflow pulse on channel i (i = 0..2) sets that channel's flag at the next clock edge whatever the channel's enable bit is. Flags read back in bits 9, 10 and 11 of register index 0.
- R2: A write to register index 0 clears each flag whose data bit (9, 10, 11) is 1 and leaves flags whose data bit is 0 unchanged. If an underflow pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R3: A channel takes part in arbitration only when its flag is 1 and its enable bit is 1. Enables sit in bits 9..11 of register index 1. Clearing an enable bit withdraws the request and leaves the flag set.
- R4: The level of channel 0 sits in bits 10:8 of register index 2. The level of channel 1 sits in bits 2:0 of register index 3, and the level of channel 2 in bits 10:8 of register index 3. All other bits of these registers read 0.
- R5: Among the pending, enabled channels, the one with the highest level wins. On equal levels, channel 0 beats channel 1 and channel 1 beats channel 2.
- R6: A request is raised only if core_ie is 1, nmi_pend is 0 and the winner's level is strictly greater than core_il. The check applies to the arbitration winner only.
- R7: A request from channels 0, 1 and 2 carries vector 13, 14 and 15 with address 0x8000 + 4 × vector, which gives 0x8034, 0x8038 and 0x803C.
- R8: irq_req, irq_vec, irq_addr and irq_lvl are registered and reflect the flags, enables, levels and core inputs as they stood just before the previous clock edge. While irq_req is 0, the other three outputs are 0.
- R9: irq_ack, asserted while irq_req is 1, clears the flag of the channel named by the current request at the next edge. An underflow pulse on that channel in the same cycle keeps the flag set.
- R10: After synchronous reset, all flags, enables and levels are 0 and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_uflow | input | 3 | Underflow pulses, one bit per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index (0 flags, 1 enables, 2 and 3 levels) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| core_ie | input | 1 | Core global interrupt enable |
| core_il | input | 3 | Core current interrupt level |
| nmi_pend | input | 1 | Higher-priority cause active |
| irq_ack | input | 1 | Core acknowledges the current request |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Vector number of the request |
| irq_addr | output | 16 | Vector address of the request |
| irq_lvl | output | 3 | Level of the request |

## Verification
A pulse, register write or acknowledge reaches the flag, enable or level state at the first clock edge. The register read port shows that new state in the same low clock phase. The request outputs follow one edge later, so a pulse appears on irq_req two edges after it is driven. A change on core_ie, core_il or nmi_pend shows up one edge later. The bench drives every input and samples every output on the falling edge. For each stimulus it checks the output once in the cycle before the result is due, where the old value must still be present, and again in the cycle the result is due.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int CH_COUNT      = 3;
    localparam int CH_IDX_W      = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1;
    localparam int LVL_W         = 3;
    localparam int WORD_W        = 16;
    localparam int VEC_W         = 8;
    localparam int ADDR_W        = 16;
    localparam int FLAG_BASE_BIT = 9;
    localparam int LVL_HALF_BITS = 8;
    localparam int VEC_FIRST     = 13;
    localparam int VEC_STRIDE_SH = 2;
    localparam logic [ADDR_W-1:0] VEC_BASE = 16'h8000;

    typedef logic [LVL_W-1:0]    lvl_t;
    typedef logic [CH_IDX_W-1:0] ch_idx_t;
    typedef logic [WORD_W-1:0]   word_t;
    typedef logic [VEC_W-1:0]    vec_t;
    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [CH_COUNT-1:0] ch_mask_t;

    typedef enum logic [1:0] {
        SEL_FLAG   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_LVL_A  = 2'd2,
        SEL_LVL_B  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic    found;
        ch_idx_t ch;
        lvl_t    lvl;
    } arb_res_t;

    typedef struct packed {
        logic  req;
        vec_t  vec;
        addr_t addr;
        lvl_t  lvl;
    } irq_out_t;

    // Level fields occupy half-word slots; slot 0 is unused, channel i owns slot i+1.
    function automatic reg_sel_e lvl_reg(input int ch);
        return ((ch + 1) / 2 == 0) ? SEL_LVL_A : SEL_LVL_B;
    endfunction

    function automatic int lvl_lsb(input int ch);
        return ((ch + 1) % 2) * LVL_HALF_BITS;
    endfunction

    function automatic vec_t ch_vector(input ch_idx_t ch);
        return vec_t'(VEC_FIRST) + vec_t'(ch);
    endfunction

    function automatic addr_t vec_address(input vec_t v);
        return VEC_BASE + (addr_t'(v) << VEC_STRIDE_SH);
    endfunction

endpackage

// File: rtl/tic_regs.sv
module tic_regs
    import tic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  reg_sel_e             sel,
    input  word_t                wdata,
    output word_t                rdata,
    input  ch_mask_t             set_pulse,
    input  ch_mask_t             ack_clr,
    output ch_mask_t             flags,
    output ch_mask_t             enables,
    output lvl_t [CH_COUNT-1:0]  levels
);

    ch_mask_t w1c;

    always_comb begin
        for (int i = 0; i < CH_COUNT; i++) begin
            w1c[i] = wr_en && (sel == SEL_FLAG) && wdata[FLAG_BASE_BIT + i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (flags & ~(w1c | ack_clr)) | set_pulse;
            if (wr_en && sel == SEL_ENABLE) begin
                enables <= wdata[FLAG_BASE_BIT +: CH_COUNT];
            end
        end
    end

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_lvl
        localparam reg_sel_e OWN_SEL = lvl_reg(g);
        localparam int       OWN_LSB = lvl_lsb(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                levels[g] <= '0;
            end else if (wr_en && sel == OWN_SEL) begin
                levels[g] <= wdata[OWN_LSB +: LVL_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_FLAG:   rdata[FLAG_BASE_BIT +: CH_COUNT] = flags;
            SEL_ENABLE: rdata[FLAG_BASE_BIT +: CH_COUNT] = enables;
            default: begin
                for (int i = 0; i < CH_COUNT; i++) begin
                    if (sel == lvl_reg(i)) begin
                        rdata[lvl_lsb(i) +: LVL_W] = levels[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter
    import tic_pkg::*;
(
    input  ch_mask_t             pend,
    input  lvl_t [CH_COUNT-1:0]  levels,
    output arb_res_t             win
);

    // Scan from the highest index down; ">=" lets a lower index take a tie.
    always_comb begin
        win = '0;
        for (int i = CH_COUNT - 1; i >= 0; i--) begin
            if (pend[i] && (!win.found || levels[i] >= win.lvl)) begin
                win.found = 1'b1;
                win.ch    = ch_idx_t'(i);
                win.lvl   = levels[i];
            end
        end
    end

endmodule

// File: rtl/tic_gate.sv
module tic_gate
    import tic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  arb_res_t win,
    input  logic     core_ie,
    input  lvl_t     core_il,
    input  logic     nmi_pend,
    output irq_out_t out_q,
    output ch_idx_t  ch_q
);

    logic     accept;
    irq_out_t out_d;

    always_comb begin
        accept = win.found && core_ie && !nmi_pend && (win.lvl > core_il);
        out_d  = '0;
        if (accept) begin
            out_d.req  = 1'b1;
            out_d.vec  = ch_vector(win.ch);
            out_d.addr = vec_address(ch_vector(win.ch));
            out_d.lvl  = win.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            ch_q  <= '0;
        end else begin
            out_q <= out_d;
            ch_q  <= accept ? win.ch : '0;
        end
    end

endmodule

// File: rtl/tic_top.sv
module tic_top
    import tic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  tmr_uflow,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        core_ie,
    input  logic [2:0]  core_il,
    input  logic        nmi_pend,
    input  logic        irq_ack,
    output logic        irq_req,
    output logic [7:0]  irq_vec,
    output logic [15:0] irq_addr,
    output logic [2:0]  irq_lvl
);

    ch_mask_t             flag_vec;
    ch_mask_t             en_vec;
    lvl_t [CH_COUNT-1:0]  lvl_vec;
    ch_mask_t             ack_clr;
    arb_res_t             win;
    irq_out_t             out_q;
    ch_idx_t              srv_ch;

    always_comb begin
        ack_clr = '0;
        if (irq_ack && out_q.req) begin
            ack_clr[srv_ch] = 1'b1;
        end
    end

    tic_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .sel       (reg_sel_e'(reg_sel)),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .set_pulse (tmr_uflow),
        .ack_clr   (ack_clr),
        .flags     (flag_vec),
        .enables   (en_vec),
        .levels    (lvl_vec)
    );

    tic_arbiter arb_i (
        .pend   (flag_vec & en_vec),
        .levels (lvl_vec),
        .win    (win)
    );

    tic_gate gate_i (
        .clk      (clk),
        .rst      (rst),
        .win      (win),
        .core_ie  (core_ie),
        .core_il  (core_il),
        .nmi_pend (nmi_pend),
        .out_q    (out_q),
        .ch_q     (srv_ch)
    );

    assign irq_req  = out_q.req;
    assign irq_vec  = out_q.vec;
    assign irq_addr = out_q.addr;
    assign irq_lvl  = out_q.lvl;

endmodule

// File: rtl/tic_checker.sv
module tic_checker
    import tic_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  tmr_uflow,
    input logic        core_ie,
    input logic [2:0]  core_il,
    input logic        nmi_pend,
    input logic        irq_req,
    input logic [7:0]  irq_vec,
    input logic [15:0] irq_addr,
    input logic [2:0]  irq_lvl,
    input ch_mask_t    flag_vec,
    input ch_mask_t    en_vec
);

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_flag
        assert_flag_latch_R1: assert property (@(posedge clk) disable iff (rst)
            tmr_uflow[g] |=> flag_vec[g]);
    end

    assert_req_needs_pending_R3: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> |($past(flag_vec & en_vec)));

    assert_req_core_gate_R6: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ($past(core_ie) && !$past(nmi_pend) && irq_lvl > $past(core_il)));

    assert_vector_map_R7: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec >= 8'd13 && irq_vec <= 8'd15 &&
                     irq_addr == 16'h8000 + {irq_vec, 2'b00}));

    assert_idle_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_req |-> (irq_vec == '0 && irq_addr == '0 && irq_lvl == '0));

endmodule

bind tic_top tic_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .tmr_uflow (tmr_uflow),
    .core_ie   (core_ie),
    .core_il   (core_il),
    .nmi_pend  (nmi_pend),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_addr  (irq_addr),
    .irq_lvl   (irq_lvl),
    .flag_vec  (flag_vec),
    .en_vec    (en_vec)
);

// File: tb/tic_top_tb_top.sv
module tic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  tmr_uflow;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        core_ie;
    logic [2:0]  core_il;
    logic        nmi_pend;
    logic        irq_ack;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic [15:0] irq_addr;
    logic [2:0]  irq_lvl;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tic_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .tmr_uflow (tmr_uflow),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .core_ie   (core_ie),
        .core_il   (core_il),
        .nmi_pend  (nmi_pend),
        .irq_ack   (irq_ack),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec),
        .irq_addr  (irq_addr),
        .irq_lvl   (irq_lvl)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [2:0] m);
        tmr_uflow = m;
        step();
        tmr_uflow = '0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [15:0] exp, input string tag);
        reg_sel = sel;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: reg %0d actual %h expected %h", tag, sel, reg_rdata, exp);
        end
    endtask

    task automatic out_chk(input logic req, input logic [7:0] vec, input logic [2:0] lvl,
                           input string tag);
        logic [15:0] ea;
        ea = req ? (16'h8000 + 16'(vec) * 16'd4) : 16'h0000;
        n_chk++;
        if (irq_req !== req || irq_vec !== vec || irq_addr !== ea || irq_lvl !== lvl) begin
            n_fail++;
            $display("FAIL %s: actual req=%b vec=%0d addr=%h lvl=%0d expected req=%b vec=%0d addr=%h lvl=%0d",
                     tag, irq_req, irq_vec, irq_addr, irq_lvl, req, vec, ea, lvl);
        end
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 16'h0000, "R10 flags");
        rd_chk(2'd1, 16'h0000, "R10 enables");
        rd_chk(2'd2, 16'h0000, "R10 level A");
        rd_chk(2'd3, 16'h0000, "R10 level B");
        out_chk(1'b0, 8'd0, 3'd0, "R10 outputs");
    endtask

    task automatic t_masked_latch();
        pulse(3'b010);
        rd_chk(2'd0, 16'h0400, "R1 masked flag latch");
        step();
        out_chk(1'b0, 8'd0, 3'd0, "R3 masked no request");
        rd_chk(2'd0, 16'h0400, "R3 flag kept while masked");
    endtask

    task automatic t_w1c();
        wr(2'd0, 16'h0000);
        rd_chk(2'd0, 16'h0400, "R2 write 0 no effect");
        wr(2'd0, 16'h0400);
        rd_chk(2'd0, 16'h0000, "R2 write 1 clears");
        tmr_uflow = 3'b010;
        wr(2'd0, 16'h0400);
        tmr_uflow = '0;
        rd_chk(2'd0, 16'h0400, "R2 set beats clear");
        wr(2'd0, 16'h0E00);
        rd_chk(2'd0, 16'h0000, "R2 clear all");
    endtask

    task automatic t_levels();
        wr(2'd2, 16'hFFFF);
        rd_chk(2'd2, 16'h0700, "R4 level A field");
        wr(2'd3, 16'hFFFF);
        rd_chk(2'd3, 16'h0707, "R4 level B fields");
        wr(2'd2, 16'h0500);
        wr(2'd3, 16'h0302);
        rd_chk(2'd2, 16'h0500, "R4 ch0 level 5");
        rd_chk(2'd3, 16'h0302, "R4 ch1 2 ch2 3");
        wr(2'd1, 16'hFFFF);
        rd_chk(2'd1, 16'h0E00, "R3 enable field");
    endtask

    task automatic t_request();
        core_ie = 1'b1; core_il = 3'd0;
        pulse(3'b100);
        out_chk(1'b0, 8'd0, 3'd0, "R8 not yet one edge after pulse");
        step();
        out_chk(1'b1, 8'd15, 3'd3, "R7 ch2 request");
        wr(2'd1, 16'h0600);
        out_chk(1'b1, 8'd15, 3'd3, "R8 old value one edge after disable");
        step();
        out_chk(1'b0, 8'd0, 3'd0, "R3 disable withdraws");
        rd_chk(2'd0, 16'h0800, "R3 flag stays after disable");
        wr(2'd1, 16'h0E00);
        step();
        out_chk(1'b1, 8'd15, 3'd3, "R3 re-enable restores");
    endtask

    task automatic t_arb();
        pulse(3'b010);
        step();
        out_chk(1'b1, 8'd15, 3'd3, "R5 higher level wins");
        wr(2'd3, 16'h0303);
        step();
        out_chk(1'b1, 8'd14, 3'd3, "R5 tie lower index wins");
        pulse(3'b001);
        step();
        out_chk(1'b1, 8'd13, 3'd5, "R7 ch0 vector");
    endtask

    task automatic t_accept();
        core_il = 3'd5;
        step();
        out_chk(1'b0, 8'd0, 3'd0, "R6 equal level refused");
        core_il = 3'd4;
        step();
        out_chk(1'b1, 8'd13, 3'd5, "R6 level above accepted");
        core_ie = 1'b0;
        step();
        out_chk(1'b0, 8'd0, 3'd0, "R6 core_ie low");
        core_ie = 1'b1; nmi_pend = 1'b1;
        step();
        out_chk(1'b0, 8'd0, 3'd0, "R6 nmi blocks");
        nmi_pend = 1'b0;
        step();
        out_chk(1'b1, 8'd13, 3'd5, "R6 restored");
        core_il = 3'd0;
    endtask

    task automatic t_ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        rd_chk(2'd0, 16'h0C00, "R9 ack clears ch0");
        step();
        out_chk(1'b1, 8'd14, 3'd3, "R9 next winner after ack");
        irq_ack = 1'b1; tmr_uflow = 3'b010;
        step();
        irq_ack = 1'b0; tmr_uflow = '0;
        rd_chk(2'd0, 16'h0C00, "R9 pulse beats ack");
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        rd_chk(2'd0, 16'h0800, "R9 ack clears ch1");
        step();
        out_chk(1'b1, 8'd15, 3'd3, "R9 ch2 remains");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst = 1'b1; tmr_uflow = '0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
        core_ie = 1'b0; core_il = '0; nmi_pend = 1'b0; irq_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masked_latch();
        t_w1c();
        t_levels();
        t_request();
        t_arb();
        t_accept();
        t_ack();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule